// File: doc/BRIEF.md
# DMA Translation Unit Configuration Register Bank

This block is the configuration and fault-reporting register bank of a DMA address translation unit. A host reaches it over a simple word-addressed bus with a request, a write strobe, a word address and 32-bit data. Each register keeps only the bits its mask allows and ORs in any bits that are wired to one. One register is different: the mask identification word accumulates its writes.

The bank gives the translator three things. It gives the enable bit and the page-table base. It also gives the start of the translation window, which it decodes from a three-bit size code in the control register. The translator in turn reports faults into the bank. A fault records a status word and the faulting page address, and it raises a level interrupt. Any bus access to either fault register lowers that interrupt again.

Read data is registered. Every output is a flop.

Top module: `xrf_regfile`

## Requirements
- R1: After reset the bank reads as follows (word addresses): control (0x000) = {VERSION, 24'h0}, fault status (0x400) = 0x00800000, arbiter enable (0x402) = 0x00000003, arbitration enable (0x800) = 0x00000008, mask ID (0xC06) = 0x23000000. Every other word reads 0, and irq, win_start, pt_base and xlat_en are 0.
- R2: A control write stores only bits under 0x0000001D. A control read returns those bits ORed with VERSION in bits 31:24. xlat_en follows stored bit 0.
- R3: A control write with size code c in bits 4:2 sets win_start to 0xFFFFFFFF shifted left by 24+c. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. win_start changes only on a control write.
- R4: The page-table base (0x001) stores only bits under 0x07FFFC00. The stored value drives pt_base.
- R5: Fault status writes keep bits under 0xFF0FFFFF and force bit 23 to one. Fault address (0x401) writes are stored unmasked.
- R6: A fault capture loads fault status with 0xC0820000, plus bit 18 when the faulting access was a read. It loads fault address with fault_page and sets irq at the same edge.
- R7: Any read or write of word 0x400 or 0x401 clears irq at the edge that samples it. irq holds its value when there is neither a capture nor such an access.
- R8: When a fault capture and a bus access to the fault registers arrive in the same cycle, the capture decides both fault registers and irq stays set.
- R9: The arbiter enable register (0x402) keeps bits under 0x801F000F and forces bit 0. The slot configuration words 0x404..0x407 keep only bits under 0x00010003.
- R10: The arbitration enable register (0x800) keeps bits under 0x001F0000 and forces bit 3.
- R11: A mask ID write ORs (wdata & 0x00FFFFFF) into the current value, so no write clears a bit.
- R12: The flush words 0x005 and 0x006 and the spare words 0x600..0x603 store all 32 bits. Any other address reads 0, and writes to it change nothing.
- R13: bus_rdata updates at the edge that samples a read request and holds its value at all other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fault_cap | input | 1 | Translator reports a fault this cycle |
| fault_rd | input | 1 | Faulting access was a read |
| fault_page | input | 32 | Page address of the fault |
| irq | output | 1 | Level fault interrupt |
| win_start | output | 32 | Start of translation window |
| pt_base | output | 32 | Page-table base |
| xlat_en | output | 1 | Translation enable |

## Verification
Every result in this bank is due exactly one rising edge after its stimulus. This covers read data, register contents after a write, the decoded window start, and the interrupt being set by a capture or cleared by a fault-register access. The bench drives inputs on the falling edge and compares all outputs against its reference model on the next falling edge, which is half a cycle after the edge that produced them. Directed reads wait that same single edge before checking bus_rdata. Same-cycle capture and access is driven on purpose so that the priority rule is checked.

// File: rtl/xrf_pkg.sv
`timescale 1ns/1ps
package xrf_pkg;
  localparam int DW = 32;

  // word offsets
  localparam int OFF_CTRL   = 'h000;
  localparam int OFF_BASE   = 'h001;
  localparam int OFF_FLSH0  = 'h005;
  localparam int OFF_FLSH1  = 'h006;
  localparam int OFF_FSTAT  = 'h400;
  localparam int OFF_FADDR  = 'h401;
  localparam int OFF_ARBEN  = 'h402;
  localparam int OFF_SLOT0  = 'h404;
  localparam int OFF_ARBSEL = 'h800;
  localparam int OFF_MID    = 'hC06;

  // masks, forced bits, reset values
  localparam logic [DW-1:0] M_CTRL   = 32'h0000_001D;
  localparam logic [DW-1:0] M_BASE   = 32'h07FF_FC00;
  localparam logic [DW-1:0] M_FSTAT  = 32'hFF0F_FFFF;
  localparam logic [DW-1:0] F_FSTAT  = 32'h0080_0000;
  localparam logic [DW-1:0] M_ARBEN  = 32'h801F_000F;
  localparam logic [DW-1:0] F_ARBEN  = 32'h0000_0001;
  localparam logic [DW-1:0] R_ARBEN  = 32'h0000_0003;
  localparam logic [DW-1:0] M_SLOT   = 32'h0001_0003;
  localparam logic [DW-1:0] M_ARBSEL = 32'h001F_0000;
  localparam logic [DW-1:0] F_ARBSEL = 32'h0000_0008;
  localparam logic [DW-1:0] M_MID    = 32'h00FF_FFFF;
  localparam logic [DW-1:0] R_MID    = 32'h2300_0000;

  // captured fault status
  localparam logic [DW-1:0] CAP_BASE = 32'hC082_0000;
  localparam logic [DW-1:0] CAP_RD   = 32'h0004_0000;

  // window decode
  localparam int WIN_CODE_W = 3;
  localparam int WIN_MIN_SH = 24;
endpackage

// File: rtl/xrf_mreg.sv
`timescale 1ns/1ps
// One masked register: keep bits under MASK, OR in FORCE,
// or accumulate (OR into current) when ACCUM is set.
module xrf_mreg #(
  parameter int            DW    = 32,
  parameter logic [DW-1:0] MASK  = '1,
  parameter logic [DW-1:0] FORCE = '0,
  parameter logic [DW-1:0] RSTV  = '0,
  parameter bit            ACCUM = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] nxt;

  generate
    if (ACCUM) begin : g_acc
      assign nxt = q | (wdata & MASK);
    end else begin : g_rep
      assign nxt = (wdata & MASK) | FORCE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     q <= RSTV;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/xrf_win_decode.sv
`timescale 1ns/1ps
// Size code to window start: all ones shifted left by MIN_SH + code.
module xrf_win_decode #(
  parameter int DW     = 32,
  parameter int CODE_W = 3,
  parameter int MIN_SH = 24
) (
  input  logic [CODE_W-1:0] code,
  output logic [DW-1:0]     start
);
  always_comb start = {DW{1'b1}} << (MIN_SH + int'(code));
endmodule

// File: rtl/xrf_fault_bank.sv
`timescale 1ns/1ps
// Fault status / address pair and the level interrupt.
module xrf_fault_bank
  import xrf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stat,
  input  logic          wr_addr,
  input  logic          acc_clr,
  input  logic [DW-1:0] wdata,
  input  logic          cap,
  input  logic          cap_rd,
  input  logic [DW-1:0] cap_page,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] addr_q,
  output logic          irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= F_FSTAT;
      addr_q <= '0;
      irq_q  <= 1'b0;
    end else if (cap) begin
      // capture outranks any bus access this cycle
      stat_q <= CAP_BASE | (cap_rd ? CAP_RD : '0);
      addr_q <= cap_page;
      irq_q  <= 1'b1;
    end else begin
      if (wr_stat) stat_q <= (wdata & M_FSTAT) | F_FSTAT;
      if (wr_addr) addr_q <= wdata;
      if (acc_clr) irq_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/xrf_regfile.sv
`timescale 1ns/1ps
module xrf_regfile
  import xrf_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter logic [7:0] VERSION     = 8'h50,
  parameter int         NUM_SLOTS   = 4,
  parameter int         SPARE_WORDS = 4,
  parameter int         SPARE_BASE  = 'h600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              fault_cap,
  input  logic              fault_rd,
  input  logic [DW-1:0]     fault_page,
  output logic              irq,
  output logic [DW-1:0]     win_start,
  output logic [DW-1:0]     pt_base,
  output logic              xlat_en
);
  localparam logic [DW-1:0] VER_WORD = {VERSION, {(DW-8){1'b0}}};

  logic wr, rd;
  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;

  logic s_ctrl, s_base, s_fl0, s_fl1, s_fst, s_fad, s_arben, s_arbsel, s_mid;
  assign s_ctrl   = bus_addr == ADDR_W'(OFF_CTRL);
  assign s_base   = bus_addr == ADDR_W'(OFF_BASE);
  assign s_fl0    = bus_addr == ADDR_W'(OFF_FLSH0);
  assign s_fl1    = bus_addr == ADDR_W'(OFF_FLSH1);
  assign s_fst    = bus_addr == ADDR_W'(OFF_FSTAT);
  assign s_fad    = bus_addr == ADDR_W'(OFF_FADDR);
  assign s_arben  = bus_addr == ADDR_W'(OFF_ARBEN);
  assign s_arbsel = bus_addr == ADDR_W'(OFF_ARBSEL);
  assign s_mid    = bus_addr == ADDR_W'(OFF_MID);

  logic [DW-1:0] ctrl_q, base_q, fl0_q, fl1_q, fst_q, fad_q;
  logic [DW-1:0] arben_q, arbsel_q, mid_q;
  logic [DW-1:0] slot_q  [NUM_SLOTS];
  logic [DW-1:0] spare_q [SPARE_WORDS];

  xrf_mreg #(.DW(DW), .MASK(M_CTRL)) u_ctrl (
    .clk(clk), .rst(rst), .we(wr & s_ctrl), .wdata(bus_wdata), .q(ctrl_q));
  xrf_mreg #(.DW(DW), .MASK(M_BASE)) u_base (
    .clk(clk), .rst(rst), .we(wr & s_base), .wdata(bus_wdata), .q(base_q));
  xrf_mreg #(.DW(DW)) u_fl0 (
    .clk(clk), .rst(rst), .we(wr & s_fl0), .wdata(bus_wdata), .q(fl0_q));
  xrf_mreg #(.DW(DW)) u_fl1 (
    .clk(clk), .rst(rst), .we(wr & s_fl1), .wdata(bus_wdata), .q(fl1_q));
  xrf_mreg #(.DW(DW), .MASK(M_ARBEN), .FORCE(F_ARBEN), .RSTV(R_ARBEN)) u_arben (
    .clk(clk), .rst(rst), .we(wr & s_arben), .wdata(bus_wdata), .q(arben_q));
  xrf_mreg #(.DW(DW), .MASK(M_ARBSEL), .FORCE(F_ARBSEL), .RSTV(F_ARBSEL)) u_arbsel (
    .clk(clk), .rst(rst), .we(wr & s_arbsel), .wdata(bus_wdata), .q(arbsel_q));
  xrf_mreg #(.DW(DW), .MASK(M_MID), .RSTV(R_MID), .ACCUM(1'b1)) u_mid (
    .clk(clk), .rst(rst), .we(wr & s_mid), .wdata(bus_wdata), .q(mid_q));

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      xrf_mreg #(.DW(DW), .MASK(M_SLOT)) u_slot (
        .clk(clk), .rst(rst),
        .we(wr && bus_addr == ADDR_W'(OFF_SLOT0 + g)),
        .wdata(bus_wdata), .q(slot_q[g]));
    end
    for (genvar g = 0; g < SPARE_WORDS; g++) begin : g_spare
      xrf_mreg #(.DW(DW)) u_spare (
        .clk(clk), .rst(rst),
        .we(wr && bus_addr == ADDR_W'(SPARE_BASE + g)),
        .wdata(bus_wdata), .q(spare_q[g]));
    end
  endgenerate

  xrf_fault_bank u_fault (
    .clk(clk), .rst(rst),
    .wr_stat(wr & s_fst), .wr_addr(wr & s_fad),
    .acc_clr(bus_req & (s_fst | s_fad)),
    .wdata(bus_wdata),
    .cap(fault_cap), .cap_rd(fault_rd), .cap_page(fault_page),
    .stat_q(fst_q), .addr_q(fad_q), .irq_q(irq));

  // window start, loaded only on a control write
  logic [DW-1:0] win_dec;
  xrf_win_decode #(.DW(DW), .CODE_W(WIN_CODE_W), .MIN_SH(WIN_MIN_SH)) u_win (
    .code(bus_wdata[2 +: WIN_CODE_W]), .start(win_dec));

  always_ff @(posedge clk) begin
    if (rst)               win_start <= '0;
    else if (wr & s_ctrl)  win_start <= win_dec;
  end

  // read mux, registered
  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (s_ctrl)   rd_val = ctrl_q | VER_WORD;
    if (s_base)   rd_val = base_q;
    if (s_fl0)    rd_val = fl0_q;
    if (s_fl1)    rd_val = fl1_q;
    if (s_fst)    rd_val = fst_q;
    if (s_fad)    rd_val = fad_q;
    if (s_arben)  rd_val = arben_q;
    if (s_arbsel) rd_val = arbsel_q;
    if (s_mid)    rd_val = mid_q;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (bus_addr == ADDR_W'(OFF_SLOT0 + i)) rd_val = slot_q[i];
    for (int i = 0; i < SPARE_WORDS; i++)
      if (bus_addr == ADDR_W'(SPARE_BASE + i)) rd_val = spare_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end

  assign pt_base = base_q;
  assign xlat_en = ctrl_q[0];
endmodule

// File: rtl/xrf_regs_chk.sv
`timescale 1ns/1ps
module xrf_regs_chk
  import xrf_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic              fault_cap,
  input logic              irq,
  input logic [DW-1:0]     win_start
);
  logic f_acc;
  assign f_acc = bus_req && (bus_addr == ADDR_W'(OFF_FSTAT) ||
                             bus_addr == ADDR_W'(OFF_FADDR));

  // R6
  cap_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
    fault_cap |=> irq);

  // R7
  access_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (f_acc && !fault_cap) |=> !irq);

  // R7
  irq_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!f_acc && !fault_cap) |=> $stable(irq));

  // R3
  win_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == ADDR_W'(OFF_CTRL))
      |=> (win_start[31] && win_start[23:0] == '0));

  // R3
  win_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we && bus_addr == ADDR_W'(OFF_CTRL)) |=> $stable(win_start));

  // R5
  fstat_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_addr == ADDR_W'(OFF_FSTAT)) |=> bus_rdata[23]);

  // R9
  arben_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_addr == ADDR_W'(OFF_ARBEN)) |=> bus_rdata[0]);

  // R10
  arbsel_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_addr == ADDR_W'(OFF_ARBSEL)) |=> bus_rdata[3]);

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> $stable(bus_rdata));
endmodule

bind xrf_regfile xrf_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .fault_cap(fault_cap),
  .irq(irq), .win_start(win_start));

// File: tb/xrf_regfile_tb.sv
`timescale 1ns/1ps
module xrf_regfile_tb;
  localparam logic [31:0] VERW = 32'h5000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fault_cap = 1'b0, fault_rd = 1'b0;
  logic [31:0] fault_page = '0;
  logic        irq, xlat_en;
  logic [31:0] win_start, pt_base;

  always #10 clk = ~clk;

  xrf_regfile u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fault_cap(fault_cap), .fault_rd(fault_rd), .fault_page(fault_page),
    .irq(irq), .win_start(win_start), .pt_base(pt_base), .xlat_en(xlat_en));

  integer n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_ctrl, m_base, m_fl0, m_fl1, m_fst, m_fad, m_arben, m_arbsel, m_mid;
  logic [31:0] m_rdata, m_win;
  logic [31:0] m_slot [4];
  logic [31:0] m_spare [4];
  logic        m_irq;

  function automatic logic [31:0] mread(input logic [11:0] a);
    if (a == 12'h000) return (m_ctrl & 32'h1D) | VERW;
    if (a == 12'h001) return m_base;
    if (a == 12'h005) return m_fl0;
    if (a == 12'h006) return m_fl1;
    if (a == 12'h400) return m_fst;
    if (a == 12'h401) return m_fad;
    if (a == 12'h402) return m_arben;
    if (a >= 12'h404 && a <= 12'h407) return m_slot[a - 12'h404];
    if (a == 12'h800) return m_arbsel;
    if (a == 12'hC06) return m_mid;
    if (a >= 12'h600 && a <= 12'h603) return m_spare[a - 12'h600];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_base = 0; m_fl0 = 0; m_fl1 = 0; m_fad = 0;
      m_fst = 32'h0080_0000; m_arben = 32'h3; m_arbsel = 32'h8;
      m_mid = 32'h2300_0000; m_rdata = 0; m_win = 0; m_irq = 0;
      for (int i = 0; i < 4; i++) begin m_slot[i] = 0; m_spare[i] = 0; end
    end else begin
      if (bus_req && !bus_we) m_rdata = mread(bus_addr);
      if (bus_req && bus_we) begin
        case (bus_addr)
          12'h000: begin
            m_ctrl = bus_wdata & 32'h1D;
            m_win  = 32'hFFFF_FFFF << (24 + int'(bus_wdata[4:2]));
          end
          12'h001: m_base   = bus_wdata & 32'h07FF_FC00;
          12'h005: m_fl0    = bus_wdata;
          12'h006: m_fl1    = bus_wdata;
          12'h400: m_fst    = (bus_wdata & 32'hFF0F_FFFF) | 32'h0080_0000;
          12'h401: m_fad    = bus_wdata;
          12'h402: m_arben  = (bus_wdata & 32'h801F_000F) | 32'h1;
          12'h800: m_arbsel = (bus_wdata & 32'h001F_0000) | 32'h8;
          12'hC06: m_mid    = m_mid | (bus_wdata & 32'h00FF_FFFF);
          default: begin
            if (bus_addr >= 12'h404 && bus_addr <= 12'h407)
              m_slot[bus_addr - 12'h404] = bus_wdata & 32'h0001_0003;
            if (bus_addr >= 12'h600 && bus_addr <= 12'h603)
              m_spare[bus_addr - 12'h600] = bus_wdata;
          end
        endcase
      end
      if (bus_req && (bus_addr == 12'h400 || bus_addr == 12'h401)) m_irq = 1'b0;
      if (fault_cap) begin
        m_fst = 32'hC082_0000 | (fault_rd ? 32'h0004_0000 : 32'h0);
        m_fad = fault_page;
        m_irq = 1'b1;
      end
    end
  end

  // compare every cycle, half a cycle after the producing edge
  always @(negedge clk) begin
    if (!rst) begin
      check(irq == m_irq, "R7 irq", {31'b0, irq}, {31'b0, m_irq});
      check(win_start == m_win, "R3 win_start", win_start, m_win);
      check(pt_base == m_base, "R4 pt_base", pt_base, m_base);
      check(xlat_en == m_ctrl[0], "R2 xlat_en", {31'b0, xlat_en}, {31'b0, m_ctrl[0]});
      check(bus_rdata == m_rdata, "R13 rdata", bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic cap(input bit is_rd, input logic [31:0] pg);
    @(negedge clk); fault_cap = 1; fault_rd = is_rd; fault_page = pg;
    @(negedge clk); fault_cap = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check(irq == 1'b0 && win_start == 0 && pt_base == 0 && xlat_en == 0,
          "R1 outputs", win_start, 32'h0);
    rd(12'h000, VERW, "R1 ctrl");
    rd(12'h400, 32'h0080_0000, "R1 fstat");
    rd(12'h402, 32'h0000_0003, "R1 arben");
    rd(12'h800, 32'h0000_0008, "R1 arbsel");
    rd(12'hC06, 32'h2300_0000, "R1 mid");
    rd(12'h601, 32'h0, "R1 spare");

    // R2 control mask and version
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h5000_001D, "R2 ctrl");
    check(xlat_en == 1'b1, "R2 enable", {31'b0, xlat_en}, 32'h1);
    check(win_start == 32'h8000_0000, "R3 code7", win_start, 32'h8000_0000);

    // R3 all size codes
    for (int c = 0; c < 8; c++) begin
      wr(12'h000, 32'(c) << 2);
      check(win_start == (32'hFFFF_FFFF << (24 + c)), "R3 code", win_start,
            32'hFFFF_FFFF << (24 + c));
    end
    check(win_start == 32'h8000_0000, "R3 last", win_start, 32'h8000_0000);
    wr(12'h000, 32'h0000_0001);
    check(win_start == 32'hFF00_0000, "R3 code0", win_start, 32'hFF00_0000);
    wr(12'h001, 32'h0000_001C);
    check(win_start == 32'hFF00_0000, "R3 other write", win_start, 32'hFF00_0000);

    // R4 base mask
    wr(12'h001, 32'hFFFF_FFFF);
    rd(12'h001, 32'h07FF_FC00, "R4 base");
    check(pt_base == 32'h07FF_FC00, "R4 pt_base", pt_base, 32'h07FF_FC00);

    // R5 fault registers by bus
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, 32'hFF8F_FFFF, "R5 fstat ones");
    wr(12'h400, 32'h0);
    rd(12'h400, 32'h0080_0000, "R5 fstat zero");
    wr(12'h401, 32'hDEAD_BEEF);
    rd(12'h401, 32'hDEAD_BEEF, "R5 faddr");

    // R6 capture (read and write faults)
    cap(1'b1, 32'h1234_5000);
    check(irq == 1'b1, "R6 irq set", {31'b0, irq}, 32'h1);
    rd(12'h400, 32'hC086_0000, "R6 fstat read fault");
    rd(12'h401, 32'h1234_5000, "R6 faddr");
    cap(1'b0, 32'hABCD_E000);
    rd(12'h400, 32'hC082_0000, "R6 fstat write fault");

    // R7 clearing
    cap(1'b0, 32'h0000_1000);
    rd(12'h000, 32'h5000_0001, "R7 unrelated read");
    check(irq == 1'b1, "R7 irq held", {31'b0, irq}, 32'h1);
    rd(12'h401, 32'h0000_1000, "R7 faddr read");
    check(irq == 1'b0, "R7 cleared by read", {31'b0, irq}, 32'h0);
    cap(1'b0, 32'h0000_2000);
    wr(12'h400, 32'h0);
    check(irq == 1'b0, "R7 cleared by write", {31'b0, irq}, 32'h0);

    // R8 capture wins over same-cycle write
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 12'h400; bus_wdata = 32'h0;
    fault_cap = 1; fault_rd = 0; fault_page = 32'h7777_7000;
    @(negedge clk);
    bus_req = 0; bus_we = 0; fault_cap = 0;
    check(irq == 1'b1, "R8 irq", {31'b0, irq}, 32'h1);
    rd(12'h400, 32'hC082_0000, "R8 fstat");
    rd(12'h401, 32'h7777_7000, "R8 faddr");

    // R9 arbiter enable and slot words
    wr(12'h402, 32'h0);
    rd(12'h402, 32'h0000_0001, "R9 arben zero");
    wr(12'h402, 32'hFFFF_FFFF);
    rd(12'h402, 32'h801F_000F, "R9 arben ones");
    for (int s = 0; s < 4; s++) begin
      wr(12'h404 + 12'(s), 32'hFFFF_FFFF);
      rd(12'h404 + 12'(s), 32'h0001_0003, "R9 slot");
    end

    // R10 arbitration enable
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h001F_0008, "R10 ones");
    wr(12'h800, 32'h0);
    rd(12'h800, 32'h0000_0008, "R10 zero");

    // R11 mask ID accumulates
    wr(12'hC06, 32'h0000_00F0);
    rd(12'hC06, 32'h2300_00F0, "R11 first");
    wr(12'hC06, 32'h0F00_0001);
    rd(12'hC06, 32'h2300_00F1, "R11 or");
    wr(12'hC06, 32'h0);
    rd(12'hC06, 32'h2300_00F1, "R11 no clear");

    // R12 plain words, spare words, unmapped
    wr(12'h005, 32'hA5A5_A5A5);
    rd(12'h005, 32'hA5A5_A5A5, "R12 flush0");
    wr(12'h006, 32'h5A5A_5A5A);
    rd(12'h006, 32'h5A5A_5A5A, "R12 flush1");
    wr(12'h603, 32'h1357_9BDF);
    rd(12'h603, 32'h1357_9BDF, "R12 spare");
    wr(12'h3FF, 32'hFFFF_FFFF);
    rd(12'h3FF, 32'h0, "R12 unmapped");
    rd(12'h000, 32'h5000_0001, "R12 ctrl untouched");
    rd(12'h603, 32'h1357_9BDF, "R12 spare untouched");

    // R13 rdata holds across a write
    wr(12'h005, 32'h0);
    check(bus_rdata == 32'h1357_9BDF, "R13 hold", bus_rdata, 32'h1357_9BDF);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule